// File: doc/BRIEF.md
# Downlink Command Frame Assembler

This block turns one transponder downlink request into the exact serial bit sequence that the pulse modulator must send. A request carries a packed flag word, a separate block selector, a password word and a data word. The block decides which fields belong in the frame and assembles them into an internal frame buffer. It then hands the bits out one at a time on a valid/ready serial port, in the order they must go on air.

The frame holds up to `FRAME_BITS` bits and is built in this order. It starts with mode-dependent reference zeros. Then comes a two-bit opcode. An optional password field follows, preceded by two fixed zeros in the reference modes. After that come a lock zero, the optional data word and the optional block address. Every multi-bit field goes MSB first. The length of the frame is published with its first bit and held until the next request is accepted. A request whose frame would not fit in the buffer emits nothing and raises an error pulse instead.

Pulse widths, gaps and field switching belong to the modulator downstream and are not part of this block.

Top module: `downlink_frame_asm`

## Requirements
- R1: Flag bits 4:3 select the downlink mode. Mode 2 starts the frame with one 0 bit. Mode 3 starts it with two 0 bits. Modes 0 and 1 add no reference bit.
- R2: When flag bit 7 (reset) is set, the frame is the reference bits followed by the opcode 00 and nothing else. All other flags, the password, the data and the block are ignored.
- R3: For any non-reset command the opcode is two bits. It is 0 then 1 when flag bit 2 (test) is set. Otherwise it is 1 then flag bit 1 (page).
- R4: When flag bit 0 (password) is set, the 32-bit password follows the opcode MSB first. In modes 2 and 3, two 0 bits come between the opcode and the password.
- R5: A single lock bit of 0 follows the opcode and password unless regular-read is in effect. Regular-read is in effect when flag bit 5 is set, or as set by R8.
- R6: The 32 data bits follow the lock bit MSB first unless flag bit 6 (read) is set.
- R7: Unless regular-read is in effect, the frame ends with the block address MSB first. The address is bits 2:0 of the block selector, and its upper bits are ignored.
- R8: When flag bit 6 is set and the 8-bit block selector is 0xFF, the command is treated as a regular read. It then has no lock bit and no address.
- R9: From the cycle after a request is accepted, `frameLen` equals the number of bits in that frame. The bits appear on `bitData` with the first frame bit first, and each bit is held while `bitValid` is high and `bitReady` is low.
- R10: `cmdReady` is low from the cycle after acceptance until the last frame bit has been taken, and it returns high in the cycle after that.
- R11: If a frame would need more than `FRAME_BITS` bits, the request is accepted but no bit is emitted. In that case `frameErr` is high for exactly the one following cycle, `frameLen` reads 0 and `cmdReady` stays high.
- R12: After reset `cmdReady` is 1, while `bitValid`, `frameErr` and `frameLen` are 0.
- R13: Flag bit 8 (fast) and the choice between modes 0 and 1 do not change the frame contents or its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Request present |
| cmdReady | output | 1 | Block idle, request taken when cmdValid is high |
| cmdFlags | input | 9 | Packed flag word (positions as in R1 to R8, R13) |
| cmdBlock | input | 8 | Block selector; 0xFF with read means regular read |
| cmdPassword | input | 32 | Password word |
| cmdData | input | 32 | Data word to write |
| bitValid | output | 1 | Serial bit available |
| bitReady | input | 1 | Downstream takes the current bit |
| bitData | output | 1 | Current frame bit |
| frameLen | output | 7 | Bit count of the current frame, 0 after an error |
| frameErr | output | 1 | One-cycle pulse for a rejected oversize request |

## Verification
On every cycle the assertions check the serial handshake. They check that a stalled bit stays stable and that the request port is closed while bits are pending. They also check that each accepted request produces either bits or an error. Whenever a frame drains, a checker counter compares the number of bits taken with the published length. The actual field order, the reference bits per mode, the 0xFF regular-read rule and the masking of the block selector can only be shown by the bench. It rebuilds each expected frame from the flag rules and compares it bit for bit across directed corners and seeded random requests with random back-pressure. The oversize path is exercised on a second instance built with a smaller buffer, because with default sizes no legal request overflows.

// File: rtl/dl_frame_pkg.sv
package dl_frame_pkg;

  // flag word positions (decoded by the requester and by this block)
  localparam int F_PWD    = 0;
  localparam int F_PAGE   = 1;
  localparam int F_TEST   = 2;
  localparam int F_MODE   = 3;  // two bits: 4:3
  localparam int F_REGRD  = 5;
  localparam int F_RDCMD  = 6;
  localparam int F_RESET  = 7;
  localparam int F_FAST   = 8;
  localparam int FLAG_W   = 9;

  typedef enum logic [1:0] {
    MODE_FIXED    = 2'd0,
    MODE_LONGREF  = 2'd1,
    MODE_LEADZERO = 2'd2,
    MODE_QUAD     = 2'd3
  } dlMode_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } dlState_t;

  // control -> datapath
  typedef struct packed {
    logic load;
    logic shift;
  } dlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic overLimit;
    logic lastBit;
  } dlStatus_t;

endpackage

// File: rtl/dl_frame_path.sv
module dl_frame_path
  import dl_frame_pkg::*;
#(
  parameter int FRAME_BITS = 80,
  parameter int PWD_BITS   = 32,
  parameter int DATA_BITS  = 32,
  parameter int ADDR_BITS  = 3,
  parameter int BLK_IN_W   = 8,
  localparam int LEN_W     = $clog2(FRAME_BITS + 1),
  localparam int IDX_W     = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dlStrobe_t            strobe,
  input  logic [FLAG_W-1:0]    cmdFlags,
  input  logic [BLK_IN_W-1:0]  cmdBlock,
  input  logic [PWD_BITS-1:0]  cmdPassword,
  input  logic [DATA_BITS-1:0] cmdData,
  output dlStatus_t            status,
  output logic                 bitData,
  output logic [LEN_W-1:0]     frameLen,
  output logic                 frameErr
);

  dlMode_t                mode;
  logic                   regRead;
  logic                   refMode;
  logic [FRAME_BITS-1:0]  nxtVec;
  int                     nxtCount;
  logic [FRAME_BITS-1:0]  shReg;
  logic [LEN_W-1:0]       remain;
  logic                   overLimit;

  assign mode    = dlMode_t'(cmdFlags[F_MODE +: 2]);
  assign refMode = (mode == MODE_LEADZERO) || (mode == MODE_QUAD);
  // read aimed at the all-ones selector means "no address"
  assign regRead = cmdFlags[F_REGRD] | (cmdFlags[F_RDCMD] & (&cmdBlock));

  // Frame builder: zero bits only advance the cursor, ones are written.
  always_comb begin
    int pos;
    nxtVec = '0;
    pos    = 0;
    if (refMode) pos += 1;
    if (mode == MODE_QUAD) pos += 1;
    if (cmdFlags[F_RESET]) begin
      pos += 2;
    end else begin
      if (!cmdFlags[F_TEST] && pos < FRAME_BITS) nxtVec[IDX_W'(pos)] = 1'b1;
      pos += 1;
      if ((cmdFlags[F_TEST] || cmdFlags[F_PAGE]) && pos < FRAME_BITS)
        nxtVec[IDX_W'(pos)] = 1'b1;
      pos += 1;
      if (cmdFlags[F_PWD]) begin
        if (refMode) pos += 2;
        for (int i = PWD_BITS - 1; i >= 0; i--) begin
          if (pos < FRAME_BITS) nxtVec[IDX_W'(pos)] = cmdPassword[i];
          pos += 1;
        end
      end
      if (!regRead) pos += 1;
      if (!cmdFlags[F_RDCMD]) begin
        for (int i = DATA_BITS - 1; i >= 0; i--) begin
          if (pos < FRAME_BITS) nxtVec[IDX_W'(pos)] = cmdData[i];
          pos += 1;
        end
      end
      if (!regRead) begin
        for (int i = ADDR_BITS - 1; i >= 0; i--) begin
          if (pos < FRAME_BITS) nxtVec[IDX_W'(pos)] = cmdBlock[i];
          pos += 1;
        end
      end
    end
    nxtCount = pos;
  end

  assign overLimit = (nxtCount > FRAME_BITS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg    <= '0;
      frameLen <= '0;
      remain   <= '0;
      frameErr <= 1'b0;
    end else begin
      frameErr <= strobe.load & overLimit;
      if (strobe.load) begin
        if (overLimit) begin
          shReg    <= '0;
          frameLen <= '0;
          remain   <= '0;
        end else begin
          shReg    <= nxtVec;
          frameLen <= LEN_W'(nxtCount);
          remain   <= LEN_W'(nxtCount);
        end
      end else if (strobe.shift) begin
        shReg  <= shReg >> 1;
        remain <= remain - 1'b1;
      end
    end
  end

  assign bitData          = shReg[0];
  assign status.overLimit = overLimit;
  assign status.lastBit   = (remain == LEN_W'(1));

endmodule

// File: rtl/dl_frame_ctrl.sv
module dl_frame_ctrl
  import dl_frame_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdValid,
  input  logic      bitReady,
  input  dlStatus_t status,
  output dlStrobe_t strobe,
  output logic      cmdReady,
  output logic      bitValid
);

  dlState_t state;
  dlState_t stateNxt;

  always_comb begin
    strobe.load  = (state == ST_IDLE) && cmdValid;
    strobe.shift = (state == ST_SEND) && bitReady;
    stateNxt     = state;
    case (state)
      ST_IDLE: if (cmdValid && !status.overLimit) stateNxt = ST_SEND;
      ST_SEND: if (bitReady && status.lastBit)    stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign cmdReady = (state == ST_IDLE);
  assign bitValid = (state == ST_SEND);

endmodule

// File: rtl/downlink_frame_asm.sv
module downlink_frame_asm
  import dl_frame_pkg::*;
#(
  parameter int FRAME_BITS = 80,
  parameter int PWD_BITS   = 32,
  parameter int DATA_BITS  = 32,
  parameter int ADDR_BITS  = 3,
  parameter int BLK_IN_W   = 8,
  localparam int LEN_W     = $clog2(FRAME_BITS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  output logic                 cmdReady,
  input  logic [FLAG_W-1:0]    cmdFlags,
  input  logic [BLK_IN_W-1:0]  cmdBlock,
  input  logic [PWD_BITS-1:0]  cmdPassword,
  input  logic [DATA_BITS-1:0] cmdData,
  output logic                 bitValid,
  input  logic                 bitReady,
  output logic                 bitData,
  output logic [LEN_W-1:0]     frameLen,
  output logic                 frameErr
);

  dlStrobe_t strobe;
  dlStatus_t status;

  dl_frame_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .bitReady (bitReady),
    .status   (status),
    .strobe   (strobe),
    .cmdReady (cmdReady),
    .bitValid (bitValid)
  );

  dl_frame_path #(
    .FRAME_BITS (FRAME_BITS),
    .PWD_BITS   (PWD_BITS),
    .DATA_BITS  (DATA_BITS),
    .ADDR_BITS  (ADDR_BITS),
    .BLK_IN_W   (BLK_IN_W)
  ) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cmdFlags    (cmdFlags),
    .cmdBlock    (cmdBlock),
    .cmdPassword (cmdPassword),
    .cmdData     (cmdData),
    .status      (status),
    .bitData     (bitData),
    .frameLen    (frameLen),
    .frameErr    (frameErr)
  );

endmodule

// File: rtl/dl_frame_checker.sv
module dl_frame_checker #(
  parameter int FRAME_BITS = 80,
  localparam int LEN_W     = $clog2(FRAME_BITS + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdValid,
  input logic             cmdReady,
  input logic             bitValid,
  input logic             bitReady,
  input logic             bitData,
  input logic [LEN_W-1:0] frameLen,
  input logic             frameErr
);

  logic [LEN_W-1:0] sentCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    sentCnt <= '0;
    else if (cmdValid && cmdReady) sentCnt <= '0;
    else if (bitValid && bitReady) sentCnt <= sentCnt + 1'b1;
  end

  // R9: a stalled bit stays put
  p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && !bitReady) |=> (bitValid && $stable(bitData)));

  // R9: bits taken match the published length when the frame drains
  p_count_matches_len_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bitValid) |-> (sentCnt == frameLen));

  // R10: request port closed while bits are pending
  p_busy_closed_r10: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |-> !cmdReady);

  // R10 / R11: every accepted request yields bits or an error
  p_accept_outcome_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> (bitValid || frameErr));

  // R11: an error emits nothing and reports no length
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |-> (!bitValid && cmdReady && frameLen == '0));

  // R9: a frame in flight has a non-zero length within capacity
  p_len_bounds_r9: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |-> (frameLen != '0 && frameLen <= LEN_W'(FRAME_BITS)));

endmodule

bind downlink_frame_asm dl_frame_checker #(.FRAME_BITS(FRAME_BITS)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .cmdReady (cmdReady),
  .bitValid (bitValid),
  .bitReady (bitReady),
  .bitData  (bitData),
  .frameLen (frameLen),
  .frameErr (frameErr)
);

// File: tb/downlink_frame_asm_test.sv
module downlink_frame_asm_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [8:0]  cmdFlags = '0;
  logic [7:0]  cmdBlock = '0;
  logic [31:0] cmdPassword = '0;
  logic [31:0] cmdData = '0;
  logic        bitValid;
  logic        bitReady = 1'b0;
  logic        bitData;
  logic [6:0]  frameLen;
  logic        frameErr;

  logic        smValid = 1'b0;
  logic        smReady;
  logic [8:0]  smFlags = '0;
  logic        smBitValid;
  logic        smBitReady = 1'b0;
  logic        smBitData;
  logic [5:0]  smLen;
  logic        smErr;

  int nChecks = 0;
  int nErrors = 0;

  always #5 clk = ~clk;

  downlink_frame_asm uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdFlags(cmdFlags), .cmdBlock(cmdBlock), .cmdPassword(cmdPassword),
    .cmdData(cmdData), .bitValid(bitValid), .bitReady(bitReady),
    .bitData(bitData), .frameLen(frameLen), .frameErr(frameErr)
  );

  downlink_frame_asm #(.FRAME_BITS(40)) uutSmall (
    .clk(clk), .rstN(rstN), .cmdValid(smValid), .cmdReady(smReady),
    .cmdFlags(smFlags), .cmdBlock(8'h02), .cmdPassword(32'hFFFF_0000),
    .cmdData(32'h1234_5678), .bitValid(smBitValid), .bitReady(smBitReady),
    .bitData(smBitData), .frameLen(smLen), .frameErr(smErr)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic void addBits(inout logic [127:0] v, inout int n,
                                  input logic [31:0] val, input int w);
    for (int i = w - 1; i >= 0; i--) begin
      v[n] = val[i];
      n++;
    end
  endfunction

  // expected frame from the requirements
  function automatic int buildExp(input logic [8:0] f, input logic [7:0] blk,
                                  input logic [31:0] pw, input logic [31:0] dat,
                                  output logic [127:0] v);
    int n = 0;
    bit refm, regRd;
    v = '0;
    refm  = (f[4:3] == 2'd2) || (f[4:3] == 2'd3);
    regRd = f[5] || (f[6] && blk == 8'hFF);
    if (refm) addBits(v, n, 0, 1);                    // R1
    if (f[4:3] == 2'd3) addBits(v, n, 0, 1);          // R1
    if (f[7]) begin
      addBits(v, n, 0, 2);                            // R2
    end else begin
      if (f[2]) addBits(v, n, 32'b01, 2);             // R3 test
      else      addBits(v, n, {30'd0, 1'b1, f[1]}, 2);// R3 normal
      if (f[0]) begin
        if (refm) addBits(v, n, 0, 2);                // R4
        addBits(v, n, pw, 32);
      end
      if (!regRd) addBits(v, n, 0, 1);                // R5
      if (!f[6])  addBits(v, n, dat, 32);             // R6
      if (!regRd) addBits(v, n, {29'd0, blk[2:0]}, 3);// R7
    end
    return n;
  endfunction

  task automatic sendCmd(input string tag, input logic [8:0] f, input logic [7:0] blk,
                         input logic [31:0] pw, input logic [31:0] dat);
    logic [127:0] ev, gv;
    int el, gn, guard;
    bit closed;
    el = buildExp(f, blk, pw, dat, ev);
    @(negedge clk);
    cmdFlags = f; cmdBlock = blk; cmdPassword = pw; cmdData = dat; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    check(frameErr == 1'b0, tag, "error pulse", frameErr, 0);
    check(frameLen == 7'(el), tag, "frame length", frameLen, el);
    gv = '0; gn = 0; guard = 0; closed = 1'b1;
    while (bitValid && guard < 2000) begin
      if (cmdReady) closed = 1'b0;
      bitReady = ($urandom_range(3) != 0);
      if (bitReady && gn < 128) begin
        gv[gn] = bitData;
        gn++;
      end
      @(negedge clk);
      guard++;
    end
    bitReady = 1'b0;
    check(gn == el, tag, "bit count", gn, el);
    check(gv == ev, tag, "frame bits", gv, ev);
    check(closed && cmdReady, "R10", "ready closed then reopened", {closed, cmdReady}, 2'b11);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    logic [8:0] rf;
    logic [7:0] rb;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R12 reset state
    check(cmdReady == 1'b1 && bitValid == 1'b0 && frameErr == 1'b0 && frameLen == '0,
          "R12", "reset state", {cmdReady, bitValid, frameErr, frameLen}, {3'b100, 7'd0});
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    sendCmd("R2", 9'h087, 8'h05, 32'hDEAD_BEEF, 32'hCAFE_F00D);  // reset, mode0, junk flags
    sendCmd("R1", 9'h098, 8'h03, 32'h0, 32'h0);                  // reset, mode3: 0000
    sendCmd("R1", 9'h012, 8'h06, 32'h0, 32'hA5A5_0F0F);          // mode2 write page1
    sendCmd("R3", 9'h002, 8'h01, 32'h0, 32'h8000_0001);          // page 1 opcode 11
    sendCmd("R3", 9'h006, 8'h04, 32'h0, 32'h0F0F_F0F0);          // test opcode 01
    sendCmd("R4", 9'h011, 8'h02, 32'h9ABC_DEF1, 32'h1111_2222);  // pwd in mode2
    sendCmd("R4", 9'h001, 8'h07, 32'h8765_4321, 32'h0);          // pwd in mode0
    sendCmd("R6", 9'h040, 8'h05, 32'h0, 32'hFFFF_FFFF);          // read, no data
    sendCmd("R5", 9'h060, 8'h03, 32'h0, 32'h0);                  // regular read flag
    sendCmd("R8", 9'h041, 8'hFF, 32'h1357_9BDF, 32'h0);          // read 0xFF -> regular
    sendCmd("R7", 9'h000, 8'hFF, 32'h0, 32'h4444_5555);          // write 0xFF masked to 7
    sendCmd("R7", 9'h000, 8'hA2, 32'h0, 32'h7777_8888);          // upper selector bits dropped
    sendCmd("R13", 9'h108, 8'h01, 32'h0, 32'h3C3C_C3C3);         // mode1 + fast = mode0 frame
    sendCmd("R9", 9'h019, 8'h06, 32'hFFFF_FFFF, 32'hFFFF_FFFF);  // longest frame, 74 bits

    for (int k = 0; k < 150; k++) begin
      rf = 9'($urandom);
      rb = ($urandom_range(3) == 0) ? 8'hFF : 8'($urandom);
      sendCmd("R9", rf, rb, $urandom, $urandom);
    end

    // R11 oversize on the 40-bit instance: pwd write needs 70 bits
    @(negedge clk);
    smFlags = 9'h001; smValid = 1'b1;
    @(negedge clk);
    smValid = 1'b0;
    check(smErr == 1'b1, "R11", "error pulse", smErr, 1);
    check(smLen == '0 && smBitValid == 1'b0 && smReady == 1'b1, "R11", "nothing emitted",
          {smLen, smBitValid, smReady}, {6'd0, 2'b01});
    @(negedge clk);
    check(smErr == 1'b0 && smBitValid == 1'b0, "R11", "pulse one cycle", {smErr, smBitValid}, 0);
    // a short frame still works after the error
    smFlags = 9'h080; smValid = 1'b1;
    @(negedge clk);
    smValid = 1'b0;
    check(smLen == 6'd2 && smBitValid == 1'b1 && smBitData == 1'b0, "R11", "recovery frame",
          {smLen, smBitValid, smBitData}, {6'd2, 2'b10});
    smBitReady = 1'b1;
    repeat (2) @(negedge clk);
    smBitReady = 1'b0;
    check(smBitValid == 1'b0 && smReady == 1'b1, "R11", "recovery drained",
          {smBitValid, smReady}, 2'b01);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule